// File: doc/BRIEF.md
# Packed 2-bit index vector table lookup

This block executes one SIMD table-lookup operation on 128-bit vectors. Each cycle it can accept an instruction word, a table operand, an index-source operand and a strobe. It decodes the word into three register numbers, an element size (8 or 16 bits) and a segment number. It also flags any word whose fixed bits do not match, or whose size/opcode combination is reserved.

Every destination element takes its index from a 2-bit field. These fields are packed densely inside one selected segment of the index source. The element is a copy of the table element at that index. Because an index has only two bits, only table elements 0 to 3 can ever be chosen.

The result, the register numbers and two flags (valid, undefined) are registered one cycle after the strobe. Timing never depends on operand values. Both element-size paths are always computed, and the decoded size picks between them.

Top module: `lut2_vec_lookup`

## Requirements
- R1: A word is undefined unless bits 31..24 equal 8'h4E, bit 23 is 1, bit 21 is 0, bit 15 is 0 and bits 11..10 are 00.
- R2: With bit 22 = 0 (8-bit elements) and bit 12 = 0, the word is undefined. It gives an undefined flag and no valid result.
- R3: In 8-bit mode (bit 22 = 0) the segment is bits 14..13. Result byte e (0..15) equals table byte i, where i is the 2-bit field at index-source bit 32*segment + 2*e.
- R4: In 16-bit mode (bit 22 = 1) the segment is {bits 14..13, bit 12} (0..7). Result halfword e (0..7) equals table halfword i, where i is the 2-bit field at index-source bit 16*segment + 2*e.
- R5: Table bits 127..64 never affect the result.
- R6: One cycle after a strobe, exactly one of the valid and undefined flags is high. Which one is set by R1 and R2 alone, independent of data.
- R7: A cycle without a strobe gives both flags low in the next cycle and leaves the result unchanged.
- R8: When the undefined flag is high, the result is all zeros.
- R9: On each strobe the register fields are registered to the outputs: destination from bits 4..0, table register from bits 9..5, index register from bits 20..16.
- R10: Synchronous active-low reset clears both flags and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| instr | input | 32 | Instruction word |
| tbl | input | 128 | Table operand |
| idx_src | input | 128 | Packed index operand |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_undef | output | 1 | Undefined encoding, one cycle after strobe |
| out_result | output | 128 | Lookup result |
| out_rd | output | 5 | Destination register number |
| out_rn | output | 5 | Table register number |
| out_rm | output | 5 | Index register number |

## Verification
The block keeps only one cycle of state, so a wrong segment choice, a swapped size path or a bad fixed-bit compare shows up at the ports in the cycle right after the strobe. It appears as a result that differs from a reference loop, or as the wrong one of the two flags. Every segment of both sizes is swept with random operands. A result register that fails to hold, or an undefined word that leaks data, is caught by an idle cycle and by reserved or corrupted encodings that follow a valid result.

// File: rtl/lut2_pkg.sv
// Shared constants and the decoded-instruction record for the 2-bit
// index table lookup. Assumes 5-bit register numbers and 2-bit indices.
package lut2_pkg;
    localparam int REG_W = 5;
    localparam int IDX_W = 2;
    localparam int SEG_MAX_W = 3;

    typedef struct packed {
        logic                 undef;
        logic                 wide;
        logic [SEG_MAX_W-1:0] seg;
        logic [REG_W-1:0]     rd;
        logic [REG_W-1:0]     rn;
        logic [REG_W-1:0]     rm;
    } dec_t;
endpackage

// File: rtl/lut2_decode.sv
// Instruction decoder: checks the fixed opcode bits, derives the element
// size and segment number, and extracts register numbers.
// Assumes a 32-bit word; purely combinational.
module lut2_decode
    import lut2_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    logic fixed_ok;
    logic reserved;

    // Fixed-field match and reserved size/opcode combination.
    always_comb begin
        fixed_ok = (instr[31:24] == 8'h4E) && instr[23] && !instr[21]
                   && !instr[15] && (instr[11:10] == 2'b00);
        reserved = !instr[22] && !instr[12];
    end

    // Field extraction and segment formation.
    always_comb begin
        dec.undef = !fixed_ok || reserved;
        dec.wide  = instr[22];
        dec.seg   = instr[22] ? instr[14:12] : {1'b0, instr[14:13]};
        dec.rd    = instr[4:0];
        dec.rn    = instr[9:5];
        dec.rm    = instr[20:16];
    end
endmodule

// File: rtl/lut2_seg_window.sv
// Selects one WIN_W-bit segment of the index source by segment number.
// Assumes VEC_W is a multiple of WIN_W.
module lut2_seg_window #(
    parameter int VEC_W = 128,
    parameter int WIN_W = 32,
    parameter int SEG_W = 2
) (
    input  logic [VEC_W-1:0] src,
    input  logic [SEG_W-1:0] seg,
    output logic [WIN_W-1:0] win
);
    localparam int NSEG = VEC_W / WIN_W;

    logic [WIN_W-1:0] segs [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        assign segs[g] = src[g*WIN_W +: WIN_W];
    end

    // Segment multiplexer.
    always_comb win = segs[seg];
endmodule

// File: rtl/lut2_elem_sel.sv
// For each EW-bit destination element, picks one of the lowest
// 2**IDX_W table elements using that element's packed index.
// Assumes VEC_W is a multiple of EW.
module lut2_elem_sel #(
    parameter int VEC_W = 128,
    parameter int EW    = 8,
    parameter int IDX_W = 2
) (
    input  logic [(VEC_W/EW)*IDX_W-1:0] win,
    input  logic [(1<<IDX_W)*EW-1:0]    tbl_lo,
    output logic [VEC_W-1:0]            res
);
    localparam int ELEMS = VEC_W / EW;
    localparam int NCAND = 1 << IDX_W;

    logic [EW-1:0] cand [NCAND];

    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        assign cand[c] = tbl_lo[c*EW +: EW];
    end

    for (genvar e = 0; e < ELEMS; e++) begin : g_elem
        assign res[e*EW +: EW] = cand[win[e*IDX_W +: IDX_W]];
    end
endmodule

// File: rtl/lut2_vec_lookup.sv
// Top level of the 2-bit index table lookup. Decodes the word, computes
// both element-size results every cycle (constant time), and registers
// the chosen result with valid/undefined flags one cycle after in_valid.
// Assumes synchronous active-low reset.
module lut2_vec_lookup
    import lut2_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] tbl,
    input  logic [VEC_W-1:0] idx_src,
    output logic             out_valid,
    output logic             out_undef,
    output logic [VEC_W-1:0] out_result,
    output logic [REG_W-1:0] out_rd,
    output logic [REG_W-1:0] out_rn,
    output logic [REG_W-1:0] out_rm
);
    localparam int EW_B   = 8;
    localparam int EW_H   = 16;
    localparam int WIN_B  = (VEC_W / EW_B) * IDX_W;
    localparam int WIN_H  = (VEC_W / EW_H) * IDX_W;
    localparam int SEGW_B = $clog2(VEC_W / WIN_B);
    localparam int SEGW_H = $clog2(VEC_W / WIN_H);
    localparam int LO_W   = (1 << IDX_W) * EW_H;

    dec_t             dec;
    logic [WIN_B-1:0] win_b;
    logic [WIN_H-1:0] win_h;
    logic [VEC_W-1:0] res_b;
    logic [VEC_W-1:0] res_h;
    logic             unused_tbl_hi;

    assign unused_tbl_hi = ^tbl[VEC_W-1:LO_W];

    lut2_decode dec_i (.instr(instr), .dec(dec));

    lut2_seg_window #(.VEC_W(VEC_W), .WIN_W(WIN_B), .SEG_W(SEGW_B)) win_b_i (
        .src(idx_src), .seg(dec.seg[SEGW_B-1:0]), .win(win_b));

    lut2_seg_window #(.VEC_W(VEC_W), .WIN_W(WIN_H), .SEG_W(SEGW_H)) win_h_i (
        .src(idx_src), .seg(dec.seg[SEGW_H-1:0]), .win(win_h));

    lut2_elem_sel #(.VEC_W(VEC_W), .EW(EW_B), .IDX_W(IDX_W)) sel_b_i (
        .win(win_b), .tbl_lo(tbl[(1<<IDX_W)*EW_B-1:0]), .res(res_b));

    lut2_elem_sel #(.VEC_W(VEC_W), .EW(EW_H), .IDX_W(IDX_W)) sel_h_i (
        .win(win_h), .tbl_lo(tbl[LO_W-1:0]), .res(res_h));

    // Output registers: flags every cycle, payload only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_undef  <= 1'b0;
            out_result <= '0;
            out_rd     <= '0;
            out_rn     <= '0;
            out_rm     <= '0;
        end else begin
            out_valid <= in_valid && !dec.undef;
            out_undef <= in_valid && dec.undef;
            if (in_valid) begin
                out_result <= dec.undef ? '0 : (dec.wide ? res_h : res_b);
                out_rd     <= dec.rd;
                out_rn     <= dec.rn;
                out_rm     <= dec.rm;
            end
        end
    end

    // R6: the two flags are never high together.
    a_r6_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_undef));

    // R6: a strobe always produces one flag in the next cycle.
    a_r6_strobe_answers: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid || out_undef));

    // R7: no strobe, no flags and a held result.
    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_undef && $stable(out_result)));

    // R2: 8-bit size with opcode bit clear is undefined.
    a_r2_reserved_undef: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !instr[22] && !instr[12]) |=> out_undef);

    // R8: an undefined word leaves a zero result.
    a_r8_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_undef |-> (out_result == '0));

    // R9: destination register number follows the strobed word.
    a_r9_rd_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_rd == $past(instr[4:0])));
endmodule

// File: tb/lut2_vec_lookup_tb_top.sv
module lut2_vec_lookup_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] tbl = '0;
    logic [127:0] idx_src = '0;
    logic         out_valid, out_undef;
    logic [127:0] out_result;
    logic [4:0]   out_rd, out_rn, out_rm;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    lut2_vec_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .tbl(tbl), .idx_src(idx_src), .out_valid(out_valid),
        .out_undef(out_undef), .out_result(out_result),
        .out_rd(out_rd), .out_rn(out_rn), .out_rm(out_rm));

    always #10 clk = ~clk;

    function automatic logic ref_undef(input logic [31:0] w);
        return (w[31:24] != 8'h4E) || !w[23] || w[21] || w[15]
               || (w[11:10] != 2'b00) || (!w[22] && !w[12]);
    endfunction

    function automatic logic [127:0] ref_res(input logic [31:0] w,
            input logic [127:0] t, input logic [127:0] s);
        logic [127:0] r = '0;
        int esz  = w[22] ? 16 : 8;
        int n    = 128 / esz;
        int part = w[22] ? int'(w[14:12]) : int'(w[14:13]);
        if (ref_undef(w)) return '0;
        for (int e = 0; e < n; e++) begin
            int ix = int'(s[2*(n*part+e) +: 2]);
            for (int b = 0; b < esz; b++) r[e*esz+b] = t[ix*esz+b];
        end
        return r;
    endfunction

    function automatic logic [31:0] mk(input bit wide, input bit [1:0] len,
            input bit op, input bit [4:0] rm, input bit [4:0] rn, input bit [4:0] rd);
        return 32'h4E80_0000 | (32'(wide) << 22) | (32'(rm) << 16)
               | (32'(len) << 13) | (32'(op) << 12) | (32'(rn) << 5) | 32'(rd);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic [127:0] t,
                         input logic [127:0] s);
        @(negedge clk);
        instr = w; tbl = t; idx_src = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_check(input logic [31:0] w, input logic [127:0] t,
                             input logic [127:0] s, input string tag);
        logic u;
        issue(w, t, s);
        u = ref_undef(w);
        chk(out_valid == !u && out_undef == u, {tag, " R6 flags"},
            128'({out_valid, out_undef}), 128'({!u, u}));
        chk(out_result == ref_res(w, t, s), {tag, " result"},
            out_result, ref_res(w, t, s));
        chk(out_rd == w[4:0] && out_rn == w[9:5] && out_rm == w[20:16], "R9 regs",
            128'({out_rd, out_rn, out_rm}), 128'({w[4:0], w[9:5], w[20:16]}));
    endtask

    initial begin
        logic [31:0]  w;
        logic [127:0] t, s, prev;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !out_undef, "R10 reset flags",
            128'({out_valid, out_undef}), 128'd0);
        chk(out_result == '0, "R10 reset result", out_result, '0);

        // R3: every 8-bit segment, directed index patterns and random data.
        for (int sg = 0; sg < 4; sg++) begin
            run_check(mk(0, 2'(sg), 1, 5'd1, 5'd2, 5'd3), rnd128(), '0, "R3 idx0");
            run_check(mk(0, 2'(sg), 1, 5'd4, 5'd5, 5'd6), rnd128(), '1, "R3 idx3");
            for (int k = 0; k < 10; k++)
                run_check(mk(0, 2'(sg), 1, 5'($urandom), 5'($urandom), 5'($urandom)),
                          rnd128(), rnd128(), "R3 rand");
        end
        // R4: every 16-bit segment.
        for (int sg = 0; sg < 8; sg++) begin
            run_check(mk(1, 2'(sg >> 1), sg[0], 5'd7, 5'd8, 5'd9), rnd128(),
                      {32{4'b1001}}, "R4 pattern");
            for (int k = 0; k < 10; k++)
                run_check(mk(1, 2'(sg >> 1), sg[0], 5'($urandom), 5'($urandom),
                          5'($urandom)), rnd128(), rnd128(), "R4 rand");
        end
        // R2: reserved 8-bit encoding after a valid result.
        run_check(mk(0, 2'd1, 1, 5'd1, 5'd1, 5'd1), rnd128(), rnd128(), "R3 pre");
        for (int sg = 0; sg < 4; sg++)
            run_check(mk(0, 2'(sg), 0, 5'd2, 5'd3, 5'd4), rnd128(), rnd128(), "R2 R8 reserved");
        // R1: flip each fixed bit of a legal word.
        foreach (w[b]) begin
            if (b >= 24 || b == 23 || b == 21 || b == 15 || b == 11 || b == 10) begin
                run_check(mk(1, 2'd2, 1, 5'd3, 5'd3, 5'd3), rnd128(), rnd128(), "R1 pre");
                run_check(mk(1, 2'd2, 1, 5'd3, 5'd3, 5'd3) ^ (32'd1 << b),
                          rnd128(), rnd128(), "R1 R8 fixed bit");
            end
        end
        // R5: upper table half has no effect.
        for (int k = 0; k < 6; k++) begin
            w = mk(1'(k), 2'(k), 1, 5'd1, 5'd2, 5'd3);
            t = rnd128(); s = rnd128();
            issue(w, t, s);
            prev = out_result;
            issue(w, {~t[127:64], t[63:0]}, s);
            chk(out_result == prev, "R5 upper table", out_result, prev);
        end
        // R7: idle cycle holds result and drops flags.
        run_check(mk(1, 2'd3, 1, 5'd1, 5'd2, 5'd3), rnd128(), rnd128(), "R7 pre");
        prev = out_result;
        @(negedge clk);
        instr = mk(0, 2'd0, 1, 5'd9, 5'd9, 5'd9); tbl = rnd128(); idx_src = rnd128();
        @(negedge clk);
        chk(!out_valid && !out_undef, "R7 idle flags",
            128'({out_valid, out_undef}), 128'd0);
        chk(out_result == prev, "R7 idle hold", out_result, prev);
        // Mixed random words, legal and not.
        for (int k = 0; k < 400; k++) begin
            w = ($urandom % 2) ? mk(1'($urandom), 2'($urandom), 1'($urandom),
                5'($urandom), 5'($urandom), 5'($urandom)) : $urandom;
            if (k % 5 == 0) w = w ^ (32'd1 << ($urandom % 32));
            run_check(w, rnd128(), rnd128(), "R1 R6 mixed");
        end
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule